// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is one 8-bit general-purpose I/O port on a small processor bus. Each pin has an output latch bit and a direction bit. A pin in output mode drives its latch value through the pad output-enable. A pin in input mode has its driver switched off, and its level is sampled through a two-stage synchronizer.

The processor reaches the port through a single-cycle bus. Each access selects either the port data or the direction register. A write is one of four operations: a byte write, or a set, clear or invert of one bit. Reads are registered.

For each bit, a read of the port data returns the latch value if the pin is an output and the synchronized pin level if it is an input. A bit operation works on the whole byte. It takes that same per-bit read view, changes one bit, and writes all eight bits back into the latch. After a bit operation, the latch bits of input pins therefore hold the sampled pin levels, and their earlier contents are lost.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch is 0x00. Every direction bit is 1 (input), so `pad_oe` is 0x00. `bus_rdata` is 0x00.
- R2: A byte write (`bus_op`=00) with `bus_sel`=0 loads `bus_wdata` into the latch whatever the direction. The latch is visible on `pad_out` one cycle later.
- R3: A direction bit of 0 means output and 1 means input. `pad_oe[i]` is 1 exactly when direction bit i is 0. A direction write shows on `pad_oe` in the next cycle.
- R4: The latch keeps its value in every cycle that has no port-data write (`bus_we`=0 or `bus_sel`=1).
- R5: A read with `bus_sel`=0 returns the latch for output bits and the synchronized pin level for input bits. The read leaves the latch unchanged.
- R6: A read with `bus_sel`=1 returns the direction register. `bus_rdata` is updated one cycle after `bus_re` and otherwise holds its last value.
- R7: A bit operation on the port data is a whole-byte read-modify-write of the R5 read view. Every input bit's latch takes its synchronized pin level.
- R8: `bus_op` encodes 00 byte write, 01 set bit, 10 clear bit and 11 invert bit. `bus_bit` selects the target bit, 0 to 7.
- R9: With `bus_sel`=1, all four operations act on the direction register's own stored value.
- R10: Pin levels pass through two flops. A read issued in the cycle a pin changes still returns the old level. A read two cycles later returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 = port data, 1 = direction register |
| bus_op | input | 2 | Write operation (R8 encoding) |
| bus_bit | input | 3 | Target bit of a bit operation |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output data (latch contents) |

## Verification
The bench builds the block with its defaults: 8 pins and 2 synchronizer stages. With 8 pins, a single byte can mix input and output bits. This lets the bench show, in one operation, input-bit latches being overwritten while output bits keep their latch values. With 2 stages, the bench can check the exact cycle in which a pin change becomes readable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned PORT_W = 8;
    localparam int unsigned IDX_W  = $clog2(PORT_W);

    typedef enum logic [1:0] {
        OP_BYTE = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_INV  = 2'b11
    } gpio_op_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] rdata;
    } gpio_regs_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_in;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_modify.sv
module gpio_modify
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] base,
    input  gpio_op_e         op,
    input  logic [IW-1:0]    bit_idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] mask;

    always_comb begin
        mask = '0;
        mask[bit_idx] = 1'b1;
        unique case (op)
            OP_BYTE: result = wdata;
            OP_SET:  result = base | mask;
            OP_CLR:  result = base & ~mask;
            OP_INV:  result = base ^ mask;
            default: result = base;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic              bus_sel,
    input  logic [1:0]        bus_op,
    input  logic [IDX_W-1:0]  bus_bit,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);
    gpio_regs_t        regs_d, regs_q;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] port_view;
    logic [PORT_W-1:0] latch_new, dir_new;
    gpio_op_e          op_e;

    assign op_e = gpio_op_e'(bus_op);

    gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Per-bit read view: pins for inputs, latch for outputs
    assign port_view = (regs_q.dir & pin_sync) | (~regs_q.dir & regs_q.latch);

    gpio_modify #(.WIDTH(PORT_W)) u_mod_latch (
        .base    (port_view),
        .op      (op_e),
        .bit_idx (bus_bit),
        .wdata   (bus_wdata),
        .result  (latch_new)
    );

    gpio_modify #(.WIDTH(PORT_W)) u_mod_dir (
        .base    (regs_q.dir),
        .op      (op_e),
        .bit_idx (bus_bit),
        .wdata   (bus_wdata),
        .result  (dir_new)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_we && !bus_sel) regs_d.latch = latch_new;
        if (bus_we &&  bus_sel) regs_d.dir   = dir_new;
        if (bus_re)             regs_d.rdata = bus_sel ? regs_q.dir : port_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.latch <= '0;
            regs_q.dir   <= '1;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pad_oe    = ~regs_q.dir;
    assign pad_out   = regs_q.latch;
    assign bus_rdata = regs_q.rdata;

    // Assertions
    assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel && bus_op == 2'b00) |=> pad_out == $past(bus_wdata));

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel && bus_op == 2'b00) |=> pad_oe == ~$past(bus_wdata));

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_sel) |=> $stable(pad_oe));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && !bus_sel) |=> $stable(pad_out));

    assert_dir_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_sel) |=> bus_rdata == ~$past(pad_oe));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    assert_out_bits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel && bus_op != 2'b00)
        |=> ((pad_out ^ $past(pad_out)) & $past(pad_oe) & ~(8'd1 << $past(bus_bit))) == '0);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0, bus_sel = 1'b0;
    logic [1:0] bus_op = 2'b00;
    logic [2:0] bus_bit = 3'd0;
    logic [7:0] bus_wdata = 8'h00, pad_in = 8'h00;
    logic [7:0] bus_rdata, pad_oe, pad_out;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_sel(bus_sel), .bus_op(bus_op), .bus_bit(bus_bit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // {sel, op, bit, wdata, pin, exp_out, exp_oe}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 2'b00, 3'd0, 8'hF0, 8'h00, 8'h00, 8'h0F}, // R3 dir write
        {1'b0, 2'b00, 3'd0, 8'hA5, 8'h00, 8'hA5, 8'h0F}, // R2 byte write
        {1'b0, 2'b01, 3'd1, 8'h00, 8'hF0, 8'hF7, 8'h0F}, // R7 R8 set
        {1'b0, 2'b10, 3'd0, 8'h00, 8'h30, 8'h36, 8'h0F}, // R7 R8 clear
        {1'b0, 2'b11, 3'd7, 8'h00, 8'h00, 8'h86, 8'h0F}, // R7 R8 invert
        {1'b1, 2'b01, 3'd0, 8'h00, 8'h00, 8'h86, 8'h0E}, // R9 dir set
        {1'b1, 2'b11, 3'd7, 8'h00, 8'h00, 8'h86, 8'h8E}, // R9 dir invert
        {1'b0, 2'b00, 3'd0, 8'hFF, 8'h00, 8'hFF, 8'h8E}, // R2 write input bits
        {1'b1, 2'b00, 3'd0, 8'h00, 8'h00, 8'hFF, 8'hFF}, // R3 all outputs
        {1'b0, 2'b10, 3'd3, 8'h00, 8'h00, 8'hF7, 8'hFF}  // R7 clear, all outputs
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic sel, input logic [1:0] op,
                            input logic [2:0] b, input logic [7:0] d);
        bus_we = 1'b1; bus_sel = sel; bus_op = op; bus_bit = b; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic sel);
        bus_re = 1'b1; bus_sel = sel;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        wait_cyc(1);
        do_read(1'b1);
        chk("R1 dir all inputs", bus_rdata, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            pad_in = VEC[i][23:16];
            wait_cyc(3);
            do_write(VEC[i][37], VEC[i][36:35], VEC[i][34:32], VEC[i][31:24]);
            chk($sformatf("R2/R3/R7/R8/R9 vec%0d out", i), pad_out, VEC[i][15:8]);
            chk($sformatf("R3/R9 vec%0d oe", i), pad_oe, VEC[i][7:0]);
        end

        // R4 hold across idle cycles
        wait_cyc(4);
        chk("R4 latch held", pad_out, 8'hF7);

        // R5 mixed read: high nibble inputs
        do_write(1'b1, 2'b00, 3'd0, 8'hF0);
        pad_in = 8'h5A;
        wait_cyc(3);
        do_read(1'b0);
        chk("R5 mixed read", bus_rdata, 8'h57);
        chk("R5 latch unchanged by read", pad_out, 8'hF7);

        // R6 direction read and hold
        do_read(1'b1);
        chk("R6 dir read", bus_rdata, 8'hF0);
        wait_cyc(2);
        chk("R6 rdata held", bus_rdata, 8'hF0);

        // R2 write with inputs: latch updated, outputs disabled on input bits
        do_write(1'b0, 2'b00, 3'd0, 8'h00);
        chk("R2 latch in input mode", pad_out, 8'h00);
        chk("R3 oe unchanged", pad_oe, 8'h0F);

        // R10 synchronizer latency
        pad_in = 8'hA5;
        do_read(1'b0);
        chk("R10 old level", bus_rdata, 8'h50);
        wait_cyc(1);
        do_read(1'b0);
        chk("R10 new level", bus_rdata, 8'hA0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule